// File: doc/BRIEF.md
# Extended Display Register File

This block holds the extended CRT controller registers of a legacy SVGA display adapter. Software reaches every register through one byte-wide index and one byte-wide data path. Several logical fields are too wide for one byte, so their slices are spread over different indices:

- the upper display start address bits (16 to 20),
- the 7-bit memory bank number,
- the upper bits (8 to 9) of the logical scan length.

A write to any of these indices updates only its own slice of the shared field. A read of any of them assembles its byte from the live merged field, so it shows slices that were written through other indices.

A key register guards the low bank nibble. Some read-only indices return fixed identification bytes. The block raises two one-cycle pulses. The first marks a write that really changes a merged field. The second marks a write that changes a timing-overflow bit, which requires the display to be resized.

Top module: `ext_crtc_regfile`

## Requirements
- R1: A write to index 0x35 has no effect at all unless the register at index 0x38 holds the unlock key (default 0x48).
- R2: An accepted write to 0x35 stores data bits 7:4 and loads bank bits 3:0 from data bits 3:0. A read of 0x35 returns the stored nibble in bits 7:4 and bank bits 3:0 in bits 3:0.
- R3: A write to 0x51 performs four updates: data bits 1:0 go to display start bits 19:18, bits 3:2 go to bank bits 5:4, bits 5:4 go to scan length bits 9:8, and bits 7:6 are stored.
- R4: A read of 0x51 returns the following fields:
  - display start bits 17:16 in bits 1:0,
  - bank bits 5:4 in bits 3:2,
  - scan length bits 9:8 in bits 5:4,
  - the stored bits in 7:6.
- R5: A write to 0x43 sets scan length bit 8 from data bit 2 and stores the byte with bit 2 cleared. A read of 0x43 ORs scan length bit 8 into bit 2.
- R6: Display start bits 17:16 are set from bits 5:4 of a write to 0x31, and 0x31 reads back the full byte. A write to 0x69 sets display start bits 20:16 from data bits 4:0. A read of 0x69 returns those five bits, with zeros above them.
- R7: A write to 0x6A loads all seven bank bits from data bits 6:0. A read of 0x6A returns the bank with bit 7 zero.
- R8: Reads of the identification indices return fixed values: 0x2D reads 0x88, 0x2E reads 0x11, 0x2F reads 0x00, 0x30 reads 0xE1 and 0x37 reads 0x2B. Any index without a register reads 0x00.
- R9: `resize_req` pulses in the cycle after a write only when one of these bits changes:
  - bit 5 of 0x42,
  - bits 1:0 of 0x5D,
  - bits 1:0 of 0x5E.

  Bit 6 of 0x5E drives `line_cmp_hi`.
- R10: `field_changed` is high for exactly the cycle after a write that alters the display start, bank, scan length or line-compare bit. It stays low after a write that leaves all of them unchanged.
- R11: Reset clears every field and stored register, and the key registers reset to a non-key value (0x00). The plain registers return the last byte written; these are 0x38, 0x39, 0x3A, 0x40, 0x41, 0x42, 0x50, 0x52, 0x53, 0x55, 0x58, 0x59, 0x5A, 0x5D, 0x5E, 0x67 and 0x6B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed index |
| idx | input | 8 | Register index for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `idx`, combinational |
| disp_start_hi | output | 5 | Display start address bits 20:16 |
| mem_bank | output | 7 | Memory bank number, shared by reads and writes |
| scan_len_hi | output | 2 | Logical scan length bits 9:8 |
| line_cmp_hi | output | 1 | Line compare bit 10 |
| resize_req | output | 1 | One-cycle pulse after a timing-overflow change |
| field_changed | output | 1 | One-cycle pulse after a merged field changes |

## Verification
The bench builds the block with its default parameters: unlock key 0x48 and a key reset value of 0x00. This means the lock starts closed, and the bench has to open it explicitly before any write to 0x35 can take effect.

With these values, one sequence of writes reaches every slice overlap:
- 0x51 and 0x43 both drive scan length bit 8,
- 0x31, 0x51 and 0x69 all drive the display start,
- 0x35, 0x51 and 0x6A all drive the bank.

Each overlap is read back from several indices. The bench also re-locks the key and confirms that the bank and the stored nibble keep their values.

// File: rtl/ext_regs_pkg.sv
package ext_regs_pkg;

    localparam int IDX_W  = 8;
    localparam int DAT_W  = 8;
    localparam int DS_W   = 5;   // display start bits 20:16
    localparam int BANK_W = 7;
    localparam int SL_W   = 2;   // scan length bits 9:8

    typedef struct packed {
        logic [DS_W-1:0]   ds;
        logic [BANK_W-1:0] bank;
        logic [SL_W-1:0]   sl;
        logic              lc;
    } merged_t;

    localparam logic [IDX_W-1:0] IX_MEMCFG  = 8'h31;
    localparam logic [IDX_W-1:0] IX_BANKLO  = 8'h35;
    localparam logic [IDX_W-1:0] IX_KEY     = 8'h38;
    localparam logic [IDX_W-1:0] IX_MODE    = 8'h42;
    localparam logic [IDX_W-1:0] IX_EXTMODE = 8'h43;
    localparam logic [IDX_W-1:0] IX_SPLIT   = 8'h51;
    localparam logic [IDX_W-1:0] IX_HOVF    = 8'h5D;
    localparam logic [IDX_W-1:0] IX_VOVF    = 8'h5E;
    localparam logic [IDX_W-1:0] IX_DSTART  = 8'h69;
    localparam logic [IDX_W-1:0] IX_BANK    = 8'h6A;

    // Plain registers: stored and read back as whole bytes.
    localparam int N_PLAIN   = 18;
    localparam int SLOT_KEY1 = 0;
    localparam int SLOT_KEY2 = 1;
    localparam int SLOT_MODE = 14;
    localparam int SLOT_HOVF = 15;
    localparam int SLOT_VOVF = 16;

    function automatic logic [IDX_W-1:0] plain_index(input int s);
        case (s)
            0:       plain_index = 8'h38;
            1:       plain_index = 8'h39;
            2:       plain_index = 8'h3A;
            3:       plain_index = 8'h40;
            4:       plain_index = 8'h41;
            5:       plain_index = 8'h50;
            6:       plain_index = 8'h52;
            7:       plain_index = 8'h53;
            8:       plain_index = 8'h55;
            9:       plain_index = 8'h58;
            10:      plain_index = 8'h59;
            11:      plain_index = 8'h5A;
            12:      plain_index = 8'h67;
            13:      plain_index = 8'h6B;
            14:      plain_index = 8'h42;
            15:      plain_index = 8'h5D;
            16:      plain_index = 8'h5E;
            default: plain_index = 8'h31;
        endcase
    endfunction

    // Fixed identification bytes; hit=0 when the index is not one of them.
    function automatic logic [DAT_W:0] id_lookup(input logic [IDX_W-1:0] ix);
        case (ix)
            8'h2D:   id_lookup = {1'b1, 8'h88};
            8'h2E:   id_lookup = {1'b1, 8'h11};
            8'h2F:   id_lookup = {1'b1, 8'h00};
            8'h30:   id_lookup = {1'b1, 8'hE1};
            8'h37:   id_lookup = {1'b1, 8'h2B};
            default: id_lookup = '0;
        endcase
    endfunction

endpackage

// File: rtl/ext_plain_regs.sv
module ext_plain_regs
    import ext_regs_pkg::*;
#(
    parameter logic [DAT_W-1:0] KEY_RESET = 8'h00
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              idx,
    input  logic [DAT_W-1:0]              wdata,
    output logic [N_PLAIN-1:0][DAT_W-1:0] q
);
    for (genvar s = 0; s < N_PLAIN; s++) begin : g_slot
        localparam logic [DAT_W-1:0] RST_VAL =
            (s == SLOT_KEY1 || s == SLOT_KEY2) ? KEY_RESET : '0;
        always_ff @(posedge clk) begin
            if (rst)
                q[s] <= RST_VAL;
            else if (wr_en && idx == plain_index(s))
                q[s] <= wdata;
        end
    end
endmodule

// File: rtl/ext_field_merge.sv
module ext_field_merge
    import ext_regs_pkg::*;
#(
    parameter logic [DAT_W-1:0] UNLOCK_KEY = 8'h48
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              idx,
    input  logic [DAT_W-1:0]              wdata,
    input  logic [N_PLAIN-1:0][DAT_W-1:0] plain_q,
    output merged_t                       fld,
    output logic [3:0]                    bank_nib_hi,
    output logic [DAT_W-1:0]              ext_mode,
    output logic [1:0]                    split_hi,
    output logic                          resize_req,
    output logic                          field_changed
);
    merged_t          fld_n;
    logic [3:0]       nib_n;
    logic [DAT_W-1:0] mode_n;
    logic [1:0]       split_n;
    logic             resize_n;
    logic             unlocked;

    assign unlocked = (plain_q[SLOT_KEY1] == UNLOCK_KEY);

    always_comb begin
        fld_n    = fld;
        nib_n    = bank_nib_hi;
        mode_n   = ext_mode;
        split_n  = split_hi;
        resize_n = 1'b0;
        if (wr_en) begin
            case (idx)
                IX_MEMCFG: fld_n.ds[1:0] = wdata[5:4];
                IX_BANKLO: if (unlocked) begin
                    nib_n           = wdata[7:4];
                    fld_n.bank[3:0] = wdata[3:0];
                end
                IX_EXTMODE: begin
                    mode_n       = wdata & 8'hFB;
                    fld_n.sl[0]  = wdata[2];
                end
                IX_SPLIT: begin
                    fld_n.ds[3:2]   = wdata[1:0];
                    fld_n.bank[5:4] = wdata[3:2];
                    fld_n.sl        = wdata[5:4];
                    split_n         = wdata[7:6];
                end
                IX_MODE: resize_n = wdata[5] ^ plain_q[SLOT_MODE][5];
                IX_HOVF: resize_n = |(wdata[1:0] ^ plain_q[SLOT_HOVF][1:0]);
                IX_VOVF: begin
                    resize_n = |(wdata[1:0] ^ plain_q[SLOT_VOVF][1:0]);
                    fld_n.lc = wdata[6];
                end
                IX_DSTART: fld_n.ds   = wdata[DS_W-1:0];
                IX_BANK:   fld_n.bank = wdata[BANK_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fld           <= '0;
            bank_nib_hi   <= '0;
            ext_mode      <= '0;
            split_hi      <= '0;
            resize_req    <= 1'b0;
            field_changed <= 1'b0;
        end else begin
            fld           <= fld_n;
            bank_nib_hi   <= nib_n;
            ext_mode      <= mode_n;
            split_hi      <= split_n;
            resize_req    <= resize_n;
            field_changed <= (fld_n != fld);
        end
    end
endmodule

// File: rtl/ext_read_mux.sv
module ext_read_mux
    import ext_regs_pkg::*;
(
    input  logic [IDX_W-1:0]              idx,
    input  merged_t                       fld,
    input  logic [3:0]                    bank_nib_hi,
    input  logic [DAT_W-1:0]              ext_mode,
    input  logic [1:0]                    split_hi,
    input  logic [N_PLAIN-1:0][DAT_W-1:0] plain_q,
    output logic [DAT_W-1:0]              rdata
);
    logic [DAT_W:0]   id_hit;
    logic [DAT_W-1:0] plain_val;
    logic             plain_hit;

    assign id_hit = id_lookup(idx);

    always_comb begin
        plain_val = '0;
        plain_hit = 1'b0;
        for (int s = 0; s < N_PLAIN; s++) begin
            if (idx == plain_index(s)) begin
                plain_val = plain_q[s];
                plain_hit = 1'b1;
            end
        end
    end

    always_comb begin
        if (id_hit[DAT_W])
            rdata = id_hit[DAT_W-1:0];
        else if (plain_hit)
            rdata = plain_val;
        else begin
            case (idx)
                IX_BANKLO:  rdata = {bank_nib_hi, fld.bank[3:0]};
                IX_EXTMODE: rdata = ext_mode | {5'b0, fld.sl[0], 2'b0};
                IX_SPLIT:   rdata = {split_hi, fld.sl, fld.bank[5:4], fld.ds[1:0]};
                IX_DSTART:  rdata = {{(DAT_W-DS_W){1'b0}}, fld.ds};
                IX_BANK:    rdata = {{(DAT_W-BANK_W){1'b0}}, fld.bank};
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ext_crtc_regfile.sv
module ext_crtc_regfile
    import ext_regs_pkg::*;
#(
    parameter logic [7:0] UNLOCK_KEY = 8'h48,
    parameter logic [7:0] KEY_RESET  = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [4:0]  disp_start_hi,
    output logic [6:0]  mem_bank,
    output logic [1:0]  scan_len_hi,
    output logic        line_cmp_hi,
    output logic        resize_req,
    output logic        field_changed
);
    logic [N_PLAIN-1:0][DAT_W-1:0] plain_q;
    merged_t          fld;
    logic [3:0]       bank_nib_hi;
    logic [DAT_W-1:0] ext_mode;
    logic [1:0]       split_hi;

    ext_plain_regs #(.KEY_RESET(KEY_RESET)) u_plain (
        .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wdata(wdata), .q(plain_q)
    );

    ext_field_merge #(.UNLOCK_KEY(UNLOCK_KEY)) u_merge (
        .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wdata(wdata),
        .plain_q(plain_q), .fld(fld), .bank_nib_hi(bank_nib_hi),
        .ext_mode(ext_mode), .split_hi(split_hi),
        .resize_req(resize_req), .field_changed(field_changed)
    );

    ext_read_mux u_rd (
        .idx(idx), .fld(fld), .bank_nib_hi(bank_nib_hi), .ext_mode(ext_mode),
        .split_hi(split_hi), .plain_q(plain_q), .rdata(rdata)
    );

    assign disp_start_hi = fld.ds;
    assign mem_bank      = fld.bank;
    assign scan_len_hi   = fld.sl;
    assign line_cmp_hi   = fld.lc;
endmodule

// File: rtl/ext_crtc_regfile_chk.sv
module ext_crtc_regfile_chk #(
    parameter logic [7:0] UNLOCK_KEY = 8'h48,
    parameter logic [7:0] KEY_RESET  = 8'h00
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] idx,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [4:0] disp_start_hi,
    input logic [6:0] mem_bank,
    input logic [1:0] scan_len_hi,
    input logic       line_cmp_hi,
    input logic       resize_req,
    input logic       field_changed
);
    // Independent shadow of the key register, built from the write stream.
    logic [7:0] key_shadow;
    always_ff @(posedge clk) begin
        if (rst)                            key_shadow <= KEY_RESET;
        else if (wr_en && idx == 8'h38)     key_shadow <= wdata;
    end

    a_r1_locked_bank_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == 8'h35 && key_shadow != UNLOCK_KEY) |=> $stable(mem_bank));

    a_r7_bank_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == 8'h6A) |=> (mem_bank == $past(wdata[6:0])));

    a_r6_dstart_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == 8'h69) |=> (disp_start_hi == $past(wdata[4:0])));

    a_r3_split_scan: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == 8'h51) |=> (scan_len_hi == $past(wdata[5:4])));

    a_r10_change_real: assert property (@(posedge clk) disable iff (rst)
        field_changed |-> ({disp_start_hi, mem_bank, scan_len_hi, line_cmp_hi} !=
                           $past({disp_start_hi, mem_bank, scan_len_hi, line_cmp_hi})));

    a_r10_change_seen: assert property (@(posedge clk) disable iff (rst)
        !$stable({disp_start_hi, mem_bank, scan_len_hi, line_cmp_hi}) |-> field_changed);

    a_r9_resize_after_write: assert property (@(posedge clk) disable iff (rst)
        resize_req |-> $past(wr_en));

    a_r8_id_byte: assert property (@(posedge clk) disable iff (rst)
        (idx == 8'h30) |-> (rdata == 8'hE1));
endmodule

bind ext_crtc_regfile ext_crtc_regfile_chk #(
    .UNLOCK_KEY(UNLOCK_KEY), .KEY_RESET(KEY_RESET)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wdata(wdata), .rdata(rdata),
    .disp_start_hi(disp_start_hi), .mem_bank(mem_bank), .scan_len_hi(scan_len_hi),
    .line_cmp_hi(line_cmp_hi), .resize_req(resize_req), .field_changed(field_changed)
);

// File: tb/ext_crtc_regfile_bench.sv
module ext_crtc_regfile_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] idx = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [4:0] disp_start_hi;
    logic [6:0] mem_bank;
    logic [1:0] scan_len_hi;
    logic       line_cmp_hi, resize_req, field_changed;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    ext_crtc_regfile u_ext_crtc_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wdata(wdata), .rdata(rdata),
        .disp_start_hi(disp_start_hi), .mem_bank(mem_bank), .scan_len_hi(scan_len_hi),
        .line_cmp_hi(line_cmp_hi), .resize_req(resize_req), .field_changed(field_changed)
    );

    typedef struct packed {
        logic       is_read;
        logic [7:0] ix;
        logic [7:0] val;   // write data, or expected read data
        logic [7:0] req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h2D, 8'h88, 8'd8},   // R8
        '{1'b1, 8'h2E, 8'h11, 8'd8},
        '{1'b1, 8'h2F, 8'h00, 8'd8},
        '{1'b1, 8'h30, 8'hE1, 8'd8},
        '{1'b1, 8'h37, 8'h2B, 8'd8},
        '{1'b1, 8'h7F, 8'h00, 8'd8},
        '{1'b0, 8'h35, 8'hA5, 8'd1},   // R1 locked write
        '{1'b1, 8'h35, 8'h00, 8'd1},
        '{1'b0, 8'h38, 8'h48, 8'd1},
        '{1'b0, 8'h35, 8'hA5, 8'd2},   // R2
        '{1'b1, 8'h35, 8'hA5, 8'd2},
        '{1'b1, 8'h6A, 8'h05, 8'd2},
        '{1'b0, 8'h51, 8'hFF, 8'd3},   // R3
        '{1'b1, 8'h51, 8'hFC, 8'd4},   // R4
        '{1'b1, 8'h6A, 8'h35, 8'd3},
        '{1'b1, 8'h43, 8'h04, 8'd5},   // R5
        '{1'b0, 8'h43, 8'hFF, 8'd5},
        '{1'b1, 8'h43, 8'hFF, 8'd5},
        '{1'b0, 8'h43, 8'h00, 8'd5},
        '{1'b1, 8'h51, 8'hEC, 8'd5},
        '{1'b0, 8'h31, 8'h30, 8'd6},   // R6
        '{1'b1, 8'h31, 8'h30, 8'd6},
        '{1'b1, 8'h69, 8'h0F, 8'd6},
        '{1'b1, 8'h51, 8'hEF, 8'd4},
        '{1'b0, 8'h69, 8'hF2, 8'd6},
        '{1'b1, 8'h69, 8'h12, 8'd6},
        '{1'b1, 8'h51, 8'hEE, 8'd4},
        '{1'b0, 8'h6A, 8'hFF, 8'd7},   // R7
        '{1'b1, 8'h6A, 8'h7F, 8'd7},
        '{1'b1, 8'h35, 8'hAF, 8'd2},
        '{1'b0, 8'h38, 8'h00, 8'd1},   // relock
        '{1'b0, 8'h35, 8'h00, 8'd1},
        '{1'b1, 8'h35, 8'hAF, 8'd1},
        '{1'b0, 8'h40, 8'h5A, 8'd11},  // R11 plain register
        '{1'b1, 8'h40, 8'h5A, 8'd11}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write; returns with the registered results visible (cycle after the edge).
    task automatic do_write(input logic [7:0] ix, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; idx = ix; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] ix, output logic [7:0] d);
        @(negedge clk);
        idx = ix;
        #1 d = rdata;
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 bank at reset", {1'b0, mem_bank}, 8'h00);
        check("R11 dstart at reset", {3'b0, disp_start_hi}, 8'h00);
        rst = 1'b0;
        do_read(8'h38, rd); check("R11 key reset", rd, 8'h00);
        do_read(8'h51, rd); check("R11 split reset", rd, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_read) begin
                do_read(VEC[i].ix, rd);
                total++;
                if (rd !== VEC[i].val) begin
                    bad++;
                    $display("FAIL R%0d vec %0d idx %h actual=%h expected=%h",
                             VEC[i].req, i, VEC[i].ix, rd, VEC[i].val);
                end
            end else begin
                do_write(VEC[i].ix, VEC[i].val);
            end
        end

        // Port values after the table
        check("R6 dstart port", {3'b0, disp_start_hi}, 8'h12);
        check("R7 bank port", {1'b0, mem_bank}, 8'h7F);
        check("R3 scan port", {6'b0, scan_len_hi}, 8'h02);

        // R10 no pulse when value unchanged, pulse for one cycle when changed
        do_write(8'h6A, 8'h7F);
        check("R10 no change no pulse", {7'b0, field_changed}, 8'h00);
        do_write(8'h6A, 8'h00);
        check("R10 pulse on change", {7'b0, field_changed}, 8'h01);
        @(negedge clk);
        check("R10 pulse one cycle", {7'b0, field_changed}, 8'h00);

        // R9 resize rules
        do_write(8'h42, 8'h20);
        check("R9 resize on 0x42 bit5", {7'b0, resize_req}, 8'h01);
        @(negedge clk);
        check("R9 resize one cycle", {7'b0, resize_req}, 8'h00);
        do_write(8'h42, 8'h3F);
        check("R9 no resize 0x42 other bits", {7'b0, resize_req}, 8'h00);
        do_write(8'h5E, 8'h40);
        check("R9 no resize 0x5E bit6", {7'b0, resize_req}, 8'h00);
        check("R9 line compare bit", {7'b0, line_cmp_hi}, 8'h01);
        check("R10 line compare change", {7'b0, field_changed}, 8'h01);
        do_write(8'h5D, 8'h01);
        check("R9 resize on 0x5D", {7'b0, resize_req}, 8'h01);
        do_write(8'h5E, 8'h42);
        check("R9 resize on 0x5E", {7'b0, resize_req}, 8'h01);
        do_read(8'h5D, rd); check("R11 plain 0x5D", rd, 8'h01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule